// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block is the software-visible control face of one bus-master DMA channel for a disk-style drive interface. It keeps a command byte (a start bit and a transfer direction bit), a status byte (transfer active, error, drive interrupt) and the base address of the descriptor table in memory. Software reaches all three through one byte-addressable register port. Each access carries a byte offset and a size code, and the port decodes them into byte lanes.

Only a change of the start bit has an effect. A rising start reloads the engine's table pointer from the stored base. If no transfer is active, the rise also marks the channel active and sends a one-cycle kick to the descriptor-walking engine. A falling start does not abort a running transfer. The transfer ends only when the engine reports done, and that also drops the drive-select valid flag. The drive's interrupt line passes straight through to the host. Each rising edge of that line also latches a sticky status flag, which software clears by writing 1 to it.

Top module: `bmdma_regs`

## Requirements
- R1: The command byte sits at offset 0. Only bit 0 (start) and bit 3 (direction, copied to `xfer_dir`) are stored. A read of bits 1, 2 and 7:4 of the command byte returns zero.
- R2: A command write whose bit 0 equals the stored start bit causes no kick and no table-pointer load.
- R3: When a command write changes start from 0 to 1, `tbl_load` pulses for one cycle after the write edge and `tbl_ptr` takes the base value. If the channel was not active, `xfer_active` sets and `eng_kick` pulses in that same cycle. If the channel was already active, there is no kick.
- R4: When a command write changes start from 1 to 0, `xfer_active` is left unchanged. A running transfer is never cut short.
- R5: The base address occupies offsets 4 to 7, least significant byte at offset 4. A write updates only the bytes covered by the offset and size (size code 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes). Bits 1:0 of the stored base always read zero.
- R6: A read returns the byte image {base, 0, status, 0, command} (command at offset 0), shifted down by 8 × offset and masked to the access size.
- R7: `host_irq` follows `dev_irq` in the same cycle. A 0-to-1 change of `dev_irq` sets status bit 2. `dev_irq` returning to 0 leaves status unchanged.
- R8: In the status byte (offset 2), a write of 1 clears bit 2 (interrupt) or bit 1 (error). `eng_err` sets bit 1. Bit 0 mirrors `xfer_active`, and software writes do not change it.
- R9: `eng_done` clears `xfer_active` and `unit_ok`. `unit_set` loads `unit_sel` from `unit_id` and sets `unit_ok`.
- R10: After reset, the command, status and base registers read zero, `tbl_ptr` is zero, and `eng_kick`, `tbl_load`, `xfer_active` and `unit_ok` are low.
- R11: When a flag is set and cleared by software in the same cycle, the set wins. When `eng_done` coincides with a start rise, the channel restarts: the kick is issued and `xfer_active` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 3 | Byte offset of the access |
| reg_size | input | 2 | Access size code |
| reg_wdata | input | 32 | Write data, right-justified |
| reg_rdata | output | 32 | Read data, right-justified |
| eng_kick | output | 1 | One-cycle start pulse to the descriptor engine |
| tbl_load | output | 1 | One-cycle pulse: engine reloads its table pointer |
| tbl_ptr | output | AW | Table pointer value for the reload |
| xfer_active | output | 1 | Transfer active (status bit 0) |
| xfer_dir | output | 1 | Direction bit of the command byte |
| eng_done | input | 1 | Engine finished or cancelled the transfer |
| eng_err | input | 1 | Engine error report |
| unit_set | input | 1 | Load the drive-select unit |
| unit_id | input | UNIT_W | Drive unit number |
| unit_sel | output | UNIT_W | Selected drive unit |
| unit_ok | output | 1 | Drive-select unit valid |
| dev_irq | input | 1 | Drive interrupt line |
| host_irq | output | 1 | Interrupt forwarded to the host |

## Verification
Two functions can land on the same status flag in one clock edge: the latching of a drive interrupt edge and a software write-1-to-clear of that flag. The bench raises `dev_irq` in the same cycle as a status write of 0x04 and expects the flag to read as set afterwards. It also asserts `eng_done` in the same cycle as a start rise. It then expects a kick and `xfer_active` still high, not a channel that silently went idle.

// File: rtl/bmdma_regs.sv
module bmdma_regs #(
  parameter int AW     = 32,
  parameter int UNIT_W = 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_off,
  input  logic [1:0]        reg_size,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              eng_kick,
  output logic              tbl_load,
  output logic [AW-1:0]     tbl_ptr,
  output logic              xfer_active,
  output logic              xfer_dir,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              unit_set,
  input  logic [UNIT_W-1:0] unit_id,
  output logic [UNIT_W-1:0] unit_sel,
  output logic              unit_ok,
  input  logic              dev_irq,
  output logic              host_irq
);
  localparam int IW = 32 + AW;
  localparam int NL = IW / 8;
  localparam int BL = AW / 8;

  logic          start_q, dir_q, err_q, int_q, irq_q;
  logic [AW-1:0] base_q;

  logic [7:0]    size_lanes;
  logic [31:0]   size_mask;
  logic [NL-1:0] lanes;
  logic [IW-1:0] wimg, rimg, rsh;

  always_comb begin
    case (reg_size)
      2'd0:    begin size_lanes = 8'h01; size_mask = 32'h0000_00FF; end
      2'd1:    begin size_lanes = 8'h03; size_mask = 32'h0000_FFFF; end
      default: begin size_lanes = 8'h0F; size_mask = 32'hFFFF_FFFF; end
    endcase
  end

  assign lanes = NL'(size_lanes) << reg_off;
  assign wimg  = IW'(reg_wdata) << {reg_off, 3'b000};

  assign rimg = {base_q, 8'h00, 5'b0, int_q, err_q, xfer_active,
                 8'h00, 4'b0, dir_q, 2'b00, start_q};
  assign rsh       = rimg >> {reg_off, 3'b000};
  assign reg_rdata = rsh[31:0] & size_mask;

  logic cmd_hit, stat_hit, start_rise, clr_err, clr_int, irq_rise, act_left;

  assign cmd_hit    = reg_wr & lanes[0];
  assign stat_hit   = reg_wr & lanes[2];
  assign start_rise = cmd_hit & wimg[0] & ~start_q;
  assign clr_err    = stat_hit & wimg[17];
  assign clr_int    = stat_hit & wimg[18];
  assign irq_rise   = dev_irq & ~irq_q;
  assign act_left   = xfer_active & ~eng_done;

  assign host_irq = dev_irq;
  assign xfer_dir = dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q     <= 1'b0;
      dir_q       <= 1'b0;
      base_q      <= '0;
      tbl_ptr     <= '0;
      tbl_load    <= 1'b0;
      eng_kick    <= 1'b0;
      xfer_active <= 1'b0;
      err_q       <= 1'b0;
      int_q       <= 1'b0;
      irq_q       <= 1'b0;
      unit_sel    <= '0;
      unit_ok     <= 1'b0;
    end else begin
      if (cmd_hit) begin
        start_q <= wimg[0];
        dir_q   <= wimg[3];
      end
      for (int b = 0; b < BL; b++)
        if (reg_wr && lanes[4+b]) base_q[8*b +: 8] <= wimg[32 + 8*b +: 8];
      base_q[1:0] <= 2'b00;

      tbl_load    <= start_rise;
      eng_kick    <= start_rise & ~act_left;
      xfer_active <= start_rise | act_left;
      if (start_rise) tbl_ptr <= base_q;

      err_q <= eng_err  | (err_q & ~clr_err);
      int_q <= irq_rise | (int_q & ~clr_int);
      irq_q <= dev_irq;

      if (unit_set) begin
        unit_sel <= unit_id;
        unit_ok  <= 1'b1;
      end else if (eng_done) begin
        unit_ok  <= 1'b0;
      end
    end
  end
endmodule

module bmdma_regs_chk #(
  parameter int AW = 32
)(
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_off,
  input logic [31:0]   reg_wdata,
  input logic [31:0]   reg_rdata,
  input logic          eng_kick,
  input logic          tbl_load,
  input logic [AW-1:0] tbl_ptr,
  input logic          xfer_active,
  input logic          eng_done,
  input logic          unit_set,
  input logic          unit_ok,
  input logic          dev_irq,
  input logic          host_irq,
  input logic          start_q,
  input logic          int_q
);
  // R1
  cmd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_off == 3'd0) |-> ((reg_rdata[7:0] & 8'hF6) == 8'h00));

  // R2
  same_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_off == 3'd0 && reg_wdata[0] == start_q) |=> (!tbl_load && !eng_kick));

  // R3
  kick_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_kick |-> (tbl_load && xfer_active));

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_off == 3'd0 && !reg_wdata[0] && xfer_active && !eng_done) |=> xfer_active);

  // R5
  base_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_ptr[1:0] == 2'b00);

  // R7
  irq_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == dev_irq);

  // R7 R11
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_irq) |=> int_q);

  // R8
  active_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_active) |-> tbl_load);

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !(reg_wr && reg_off == 3'd0) && !unit_set) |=> (!xfer_active && !unit_ok));
endmodule

bind bmdma_regs bmdma_regs_chk #(.AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_kick(eng_kick),
  .tbl_load(tbl_load), .tbl_ptr(tbl_ptr), .xfer_active(xfer_active),
  .eng_done(eng_done), .unit_set(unit_set), .unit_ok(unit_ok),
  .dev_irq(dev_irq), .host_irq(host_irq), .start_q(start_q), .int_q(int_q)
);

// File: tb/bmdma_regs_test.sv
`timescale 1ns/1ps
module bmdma_regs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_off = '0;
  logic [1:0]  reg_size = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_kick, tbl_load, xfer_active, xfer_dir, unit_ok, host_irq;
  logic [31:0] tbl_ptr;
  logic        eng_done = 1'b0, eng_err = 1'b0, unit_set = 1'b0, dev_irq = 1'b0;
  logic [0:0]  unit_id = '0;
  logic [0:0]  unit_sel;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  bmdma_regs uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_kick(eng_kick), .tbl_load(tbl_load), .tbl_ptr(tbl_ptr),
    .xfer_active(xfer_active), .xfer_dir(xfer_dir), .eng_done(eng_done),
    .eng_err(eng_err), .unit_set(unit_set), .unit_id(unit_id),
    .unit_sel(unit_sel), .unit_ok(unit_ok), .dev_irq(dev_irq), .host_irq(host_irq)
  );

  // {write off, write size, write data, read off, read size, expected read}
  localparam logic [73:0] VEC [9] = '{
    {3'd4, 2'd2, 32'h1234_5677, 3'd4, 2'd2, 32'h1234_5674},
    {3'd5, 2'd0, 32'h0000_00AB, 3'd4, 2'd2, 32'h1234_AB74},
    {3'd6, 2'd1, 32'h0000_CDEF, 3'd4, 2'd2, 32'hCDEF_AB74},
    {3'd4, 2'd0, 32'h0000_00FF, 3'd4, 2'd2, 32'hCDEF_ABFC},
    {3'd7, 2'd0, 32'h0000_0001, 3'd6, 2'd1, 32'h0000_01EF},
    {3'd4, 2'd0, 32'h0000_0010, 3'd5, 2'd0, 32'h0000_00AB},
    {3'd0, 2'd0, 32'h0000_00F6, 3'd0, 2'd0, 32'h0000_0000},
    {3'd0, 2'd0, 32'h0000_0008, 3'd0, 2'd0, 32'h0000_0008},
    {3'd0, 2'd0, 32'h0000_0008, 3'd0, 2'd2, 32'h0000_0008}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] off, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = off; reg_size = sz; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] off, input logic [1:0] sz, output logic [31:0] d);
    reg_off = off; reg_size = sz;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  logic [31:0] r;

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R10 reset state
    rd(3'd0, 2'd2, r); chk("R10 cmd/status", r, 32'h0);
    rd(3'd4, 2'd2, r); chk("R10 base", r, 32'h0);
    chk("R10 outputs", {28'h0, eng_kick, tbl_load, xfer_active, unit_ok}, 32'h0);
    chk("R10 tbl_ptr", tbl_ptr, 32'h0);

    // R5 R6 R1 vector walk
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][73:71], VEC[i][70:69], VEC[i][68:37]);
      rd(VEC[i][36:34], VEC[i][33:32], r);
      chk($sformatf("R5 R6 R1 vector %0d", i), r, VEC[i][31:0]);
    end
    chk("R1 xfer_dir", {31'h0, xfer_dir}, 32'h1);

    // R3 start rise with idle channel
    wr(3'd0, 2'd0, 32'h09);
    chk("R3 kick", {30'h0, eng_kick, tbl_load}, 32'h3);
    chk("R3 tbl_ptr", tbl_ptr, 32'h01EF_AB10);
    rd(3'd2, 2'd0, r); chk("R3 active", r, 32'h01);
    tick();
    chk("R3 pulse width", {30'h0, eng_kick, tbl_load}, 32'h0);

    // R2 unchanged start
    wr(3'd0, 2'd0, 32'h01);
    chk("R2 no action", {30'h0, eng_kick, tbl_load}, 32'h0);

    // R4 stop while running
    wr(3'd0, 2'd0, 32'h00);
    rd(3'd2, 2'd0, r); chk("R4 still active", r, 32'h01);
    rd(3'd0, 2'd0, r); chk("R4 start cleared", r, 32'h00);

    // R3 restart while still active: reload, no kick
    wr(3'd4, 2'd2, 32'h0000_0103);
    wr(3'd0, 2'd0, 32'h01);
    chk("R3 reload active", {30'h0, eng_kick, tbl_load}, 32'h1);
    chk("R3 reload ptr", tbl_ptr, 32'h0000_0100);

    // R9 unit select and done
    @(negedge clk); unit_set = 1'b1; unit_id = 1'b1;
    @(negedge clk); unit_set = 1'b0;
    chk("R9 unit loaded", {30'h0, unit_ok, unit_sel}, 32'h3);
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
    chk("R9 done clears", {30'h0, xfer_active, unit_ok}, 32'h0);

    // R7 interrupt edge and pass-through
    @(negedge clk); dev_irq = 1'b1;
    #0.5; chk("R7 pass high", {31'h0, host_irq}, 32'h1);
    tick();
    rd(3'd2, 2'd0, r); chk("R7 int set", r, 32'h04);
    dev_irq = 1'b0;
    #0.5; chk("R7 pass low", {31'h0, host_irq}, 32'h0);
    tick();
    rd(3'd2, 2'd0, r); chk("R7 low keeps status", r, 32'h04);

    // R8 error set and write-1-to-clear
    @(negedge clk); eng_err = 1'b1;
    @(negedge clk); eng_err = 1'b0;
    rd(3'd2, 2'd0, r); chk("R8 err set", r, 32'h06);
    wr(3'd2, 2'd0, 32'h02);
    rd(3'd2, 2'd0, r); chk("R8 clear err", r, 32'h04);
    wr(3'd2, 2'd0, 32'h04);
    rd(3'd2, 2'd0, r); chk("R8 clear int", r, 32'h00);
    wr(3'd0, 2'd0, 32'h00);
    wr(3'd0, 2'd0, 32'h01);
    chk("R8 restart kick", {31'h0, eng_kick}, 32'h1);
    wr(3'd2, 2'd0, 32'h07);
    rd(3'd2, 2'd0, r); chk("R8 active read-only", r, 32'h01);

    // R11 interrupt edge against software clear
    @(negedge clk); dev_irq = 1'b1;
    @(negedge clk); dev_irq = 1'b0;
    tick();
    @(negedge clk);
    reg_wr = 1'b1; reg_off = 3'd2; reg_size = 2'd0; reg_wdata = 32'h04; dev_irq = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; dev_irq = 1'b0;
    rd(3'd2, 2'd0, r); chk("R11 set beats clear", r, 32'h05);

    // R11 done together with start rise
    wr(3'd0, 2'd0, 32'h00);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = 3'd0; reg_size = 2'd0; reg_wdata = 32'h01; eng_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; eng_done = 1'b0;
    chk("R11 done+start", {29'h0, eng_kick, tbl_load, xfer_active}, 32'h7);

    // R10 reset again mid-transfer
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(3'd0, 2'd2, r); chk("R10 re-reset regs", r, 32'h0);
    chk("R10 re-reset active", {31'h0, xfer_active}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule